// File: doc/BRIEF.md
# Floating-Point Round-to-Integral Unit

This unit takes a binary floating-point operand (double precision by default) and returns the integral value chosen by a two-bit rounding mode. The result stays in the same floating-point format. The unit never converts to an integer type, so an integer overflow cannot occur. It clears the fraction bits that lie below the binary point. When the mode calls for it, it adds one unit at the lowest kept position, and a carry out of the fraction moves naturally into the exponent field.

Conceptually there are two candidate results, the ceiling and the floor of the operand, and the mode picks one of them. The unit raises an inexact flag whenever the returned value differs from the operand. Signaling NaNs raise an invalid flag. Each result is registered, so it appears one clock after its valid strobe.

Top module: `fp_round_integral`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly one clock. `out_result` and the flags belong to the operand presented in that earlier cycle.
- R2: Mode 0 (nearest) returns whichever of the ceiling and the floor lies closer to the operand.
- R3: In mode 0, an operand exactly halfway between two integers returns the even candidate. For example, 2.5 gives 2, 3.5 gives 4 and -0.5 gives -0.
- R4: Mode 1 (toward zero) returns the floor for positive operands and the ceiling otherwise, so the magnitude never grows.
- R5: Mode 2 (toward +infinity) returns the ceiling.
- R6: Mode 3 (toward -infinity) returns the floor.
- R7: For a non-NaN operand, `out_inexact` is 1 exactly when the result differs from the operand.
- R8: Finite operands whose unbiased exponent is at least FRAC_W, and both infinities, pass through bit-for-bit with `out_inexact` 0.
- R9: A NaN operand returns the operand with its most significant fraction bit set. `out_invalid` is 1 only when that bit was 0 on input (a signaling NaN).
- R10: Every non-NaN result keeps the operand's sign bit, so a value that rounds to zero gives a zero of the same sign.
- R11: A finite operand with magnitude below 1 returns a zero or a one of the operand's sign. A one is returned in mode 0 only when the magnitude exceeds one half, and in modes 2 and 3 only when the operand is nonzero and its sign points the same way as the rounding direction.
- R12: While `out_valid` is 0, `out_inexact` and `out_invalid` are 0. During reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand strobe |
| in_op | input | 1+EXP_W+FRAC_W | Operand: sign, biased exponent, fraction |
| in_mode | input | 2 | Rounding mode: 0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward -inf |
| out_valid | output | 1 | Result strobe |
| out_result | output | 1+EXP_W+FRAC_W | Rounded value in the same format |
| out_inexact | output | 1 | Result differs from the operand |
| out_invalid | output | 1 | Operand was a signaling NaN |

## Verification
The assertions assume that `in_op` and `in_mode` are stable and known in every cycle where `in_valid` is high. The directional properties compare raw bit patterns, so they assume that magnitude order and encoding order agree, which holds for finite operands only. The bench drives inputs away from the clock edge and holds `in_valid` low between operands. It sweeps every encoding of a reduced format (5-bit exponent, 6-bit fraction) in all four modes, which covers subnormals, ties, infinities and both kinds of NaN without leaving the assumed input domain.

// File: rtl/rti_pkg.sv
package rti_pkg;

    typedef enum logic [1:0] {
        RM_NEAREST = 2'd0,
        RM_ZERO    = 2'd1,
        RM_UP      = 2'd2,
        RM_DOWN    = 2'd3
    } rmode_e;

    typedef enum logic [2:0] {
        OPC_TINY,   // magnitude below one, including zero
        OPC_FRAC,   // has fraction bits below the binary point
        OPC_WHOLE,  // already integral by exponent
        OPC_INF,
        OPC_NAN
    } opclass_e;

endpackage

// File: rtl/rti_classify.sv
module rti_classify
    import rti_pkg::*;
#(
    parameter int EXP_W = 11,
    parameter int FRAC_W = 52,
    localparam int SH_W = $clog2(FRAC_W + 1)
) (
    input  logic [EXP_W-1:0]  exp_i,
    input  logic [FRAC_W-1:0] frac_i,
    output opclass_e          cls_o,
    output logic              snan_o,
    output logic [SH_W-1:0]   int_bits_o
);
    localparam int BIAS = (1 << (EXP_W - 1)) - 1;

    always_comb begin
        int_bits_o = '0;
        snan_o     = 1'b0;
        if (&exp_i) begin
            cls_o  = (|frac_i) ? OPC_NAN : OPC_INF;
            snan_o = (|frac_i) && !frac_i[FRAC_W-1];
        end else if (int'(exp_i) < BIAS) begin
            cls_o = OPC_TINY;
        end else if (int'(exp_i) >= BIAS + FRAC_W) begin
            cls_o = OPC_WHOLE;
        end else begin
            cls_o      = OPC_FRAC;
            int_bits_o = SH_W'(int'(exp_i) - BIAS);
        end
    end

endmodule

// File: rtl/rti_frac_round.sv
module rti_frac_round
    import rti_pkg::*;
#(
    parameter int EXP_W = 11,
    parameter int FRAC_W = 52,
    localparam int SH_W = $clog2(FRAC_W + 1),
    localparam int MAG_W = EXP_W + FRAC_W
) (
    input  logic             sign_i,
    input  logic [MAG_W-1:0] mag_i,
    input  logic [SH_W-1:0]  int_bits_i,
    input  rmode_e           mode_i,
    output logic [MAG_W-1:0] mag_o,
    output logic             inexact_o
);
    logic [FRAC_W-1:0] ones_all;
    logic [FRAC_W-1:0] drop_mask;
    logic [FRAC_W-1:0] half_pt;
    logic [FRAC_W-1:0] tail;
    logic [FRAC_W:0]   unit_step;
    logic              keep_lsb;
    logic              bump;
    logic [MAG_W-1:0]  cleared;

    assign ones_all  = '1;
    assign drop_mask = ones_all >> int_bits_i;
    assign half_pt   = drop_mask ^ (drop_mask >> 1);
    assign tail      = mag_i[FRAC_W-1:0] & drop_mask;
    assign unit_step = {1'b0, drop_mask} + (FRAC_W + 1)'(1);
    assign keep_lsb  = |({1'b1, mag_i[FRAC_W-1:0]} & unit_step);
    assign cleared   = {mag_i[MAG_W-1:FRAC_W], mag_i[FRAC_W-1:0] & ~drop_mask};

    always_comb begin
        unique case (mode_i)
            RM_NEAREST: bump = (tail > half_pt) || ((tail == half_pt) && keep_lsb);
            RM_ZERO:    bump = 1'b0;
            RM_UP:      bump = !sign_i && (|tail);
            RM_DOWN:    bump = sign_i && (|tail);
            default:    bump = 1'b0;
        endcase
    end

    assign mag_o     = cleared + (bump ? MAG_W'(unit_step) : '0);
    assign inexact_o = |tail;

endmodule

// File: rtl/rti_tiny_round.sv
module rti_tiny_round
    import rti_pkg::*;
#(
    parameter int EXP_W = 11,
    parameter int FRAC_W = 52,
    localparam int MAG_W = EXP_W + FRAC_W
) (
    input  logic              sign_i,
    input  logic [EXP_W-1:0]  exp_i,
    input  logic [FRAC_W-1:0] frac_i,
    input  rmode_e            mode_i,
    output logic [MAG_W-1:0]  mag_o,
    output logic              inexact_o
);
    localparam int BIAS = (1 << (EXP_W - 1)) - 1;

    logic nonzero;
    logic over_half;
    logic to_one;

    assign nonzero   = (|exp_i) || (|frac_i);
    assign over_half = (int'(exp_i) == BIAS - 1) && (|frac_i);

    always_comb begin
        unique case (mode_i)
            RM_NEAREST: to_one = over_half;
            RM_ZERO:    to_one = 1'b0;
            RM_UP:      to_one = !sign_i && nonzero;
            RM_DOWN:    to_one = sign_i && nonzero;
            default:    to_one = 1'b0;
        endcase
    end

    assign mag_o     = to_one ? {EXP_W'(BIAS), {FRAC_W{1'b0}}} : '0;
    assign inexact_o = nonzero;

endmodule

// File: rtl/fp_round_integral.sv
module fp_round_integral
    import rti_pkg::*;
#(
    parameter int EXP_W = 11,
    parameter int FRAC_W = 52,
    localparam int W = 1 + EXP_W + FRAC_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_op,
    input  logic [1:0]   in_mode,
    output logic         out_valid,
    output logic [W-1:0] out_result,
    output logic         out_inexact,
    output logic         out_invalid
);
    localparam int SH_W  = $clog2(FRAC_W + 1);
    localparam int MAG_W = EXP_W + FRAC_W;

    typedef struct packed {
        logic         valid;
        logic [W-1:0] result;
        logic         inexact;
        logic         invalid;
    } out_t;

    out_t state_d, state_q;

    logic              op_sign;
    logic [EXP_W-1:0]  op_exp;
    logic [FRAC_W-1:0] op_frac;
    rmode_e            mode;
    opclass_e          cls;
    logic              is_snan;
    logic [SH_W-1:0]   int_bits;
    logic [MAG_W-1:0]  frac_mag, tiny_mag;
    logic              frac_inex, tiny_inex;

    assign op_sign = in_op[W-1];
    assign op_exp  = in_op[W-2:FRAC_W];
    assign op_frac = in_op[FRAC_W-1:0];
    assign mode    = rmode_e'(in_mode);

    rti_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_classify (
        .exp_i      (op_exp),
        .frac_i     (op_frac),
        .cls_o      (cls),
        .snan_o     (is_snan),
        .int_bits_o (int_bits)
    );

    rti_frac_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_frac (
        .sign_i     (op_sign),
        .mag_i      (in_op[MAG_W-1:0]),
        .int_bits_i (int_bits),
        .mode_i     (mode),
        .mag_o      (frac_mag),
        .inexact_o  (frac_inex)
    );

    rti_tiny_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_tiny (
        .sign_i    (op_sign),
        .exp_i     (op_exp),
        .frac_i    (op_frac),
        .mode_i    (mode),
        .mag_o     (tiny_mag),
        .inexact_o (tiny_inex)
    );

    always_comb begin
        state_d         = state_q;
        state_d.valid   = in_valid;
        state_d.inexact = 1'b0;
        state_d.invalid = 1'b0;
        if (in_valid) begin
            unique case (cls)
                OPC_FRAC: begin
                    state_d.result  = {op_sign, frac_mag};
                    state_d.inexact = frac_inex;
                end
                OPC_TINY: begin
                    state_d.result  = {op_sign, tiny_mag};
                    state_d.inexact = tiny_inex;
                end
                OPC_NAN: begin
                    state_d.result  = in_op | (W'(1) << (FRAC_W - 1));
                    state_d.invalid = is_snan;
                end
                default: state_d.result = in_op;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign out_valid   = state_q.valid;
    assign out_result  = state_q.result;
    assign out_inexact = state_q.inexact;
    assign out_invalid = state_q.invalid;

    // Assertions

    logic in_finite, in_nan, out_nan;
    assign in_finite = !(&op_exp);
    assign in_nan    = (&op_exp) && (|op_frac);
    assign out_nan   = (&out_result[W-2:FRAC_W]) && (|out_result[FRAC_W-1:0]);

    assert_valid_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (out_valid == $past(in_valid)));

    assert_toward_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_finite && mode == RM_ZERO |=> out_result[W-2:0] <= $past(in_op[W-2:0]));

    assert_up_pos_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_finite && !op_sign && mode == RM_UP |=> out_result[W-2:0] >= $past(in_op[W-2:0]));

    assert_down_neg_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_finite && op_sign && mode == RM_DOWN |=> out_result[W-2:0] >= $past(in_op[W-2:0]));

    assert_inexact_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !in_nan |=> out_inexact == (out_result != $past(in_op)));

    assert_nan_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_nan |=> out_nan && out_result[FRAC_W-1]
                               && (out_invalid == !$past(op_frac[FRAC_W-1])));

    assert_sign_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !in_nan |=> out_result[W-1] == $past(op_sign) && !out_invalid);

    assert_flags_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !out_inexact && !out_invalid);

endmodule

// File: tb/fp_round_integral_tb.sv
module fp_round_integral_tb;
    localparam int EXP_W  = 5;
    localparam int FRAC_W = 6;
    localparam int W      = 1 + EXP_W + FRAC_W;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int FB     = BIAS - 1 + FRAC_W;     // fixed-point fraction bits
    localparam longint ONE = longint'(1) << FB;
    localparam int EMAX   = (1 << EXP_W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_op = '0;
    logic [1:0]   in_mode = '0;
    logic         out_valid;
    logic [W-1:0] out_result;
    logic         out_inexact;
    logic         out_invalid;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    fp_round_integral #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_dut (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_op (in_op),
        .in_mode (in_mode), .out_valid (out_valid), .out_result (out_result),
        .out_inexact (out_inexact), .out_invalid (out_invalid)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s op=%0h mode=%0d actual=%0h expected=%0h",
                     req, in_op, in_mode, act, exp);
        end
    endtask

    function automatic longint mag_of(input logic [W-1:0] v);
        int e, f;
        longint sig;
        e = int'(v[W-2:FRAC_W]);
        f = int'(v[FRAC_W-1:0]);
        sig = (e == 0) ? longint'(f) : longint'(f + (1 << FRAC_W));
        if (e == 0) e = 1;
        return sig << (e - 1);
    endfunction

    task automatic run_one(input int code, input int m);
        logic   s;
        int     e, f;
        longint x, fl, ce, r, dl, du;
        string  tag;
        @(negedge clk);
        in_op    = W'(code);
        in_mode  = 2'(m);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        s = in_op[W-1];
        e = int'(in_op[W-2:FRAC_W]);
        f = int'(in_op[FRAC_W-1:0]);
        chk(out_valid == 1'b1, "R1", longint'(out_valid), 1);
        if (e == EMAX && f != 0) begin
            chk(out_result == (in_op | W'(1 << (FRAC_W - 1))), "R9", longint'(out_result),
                longint'(in_op | W'(1 << (FRAC_W - 1))));
            chk(out_invalid == !in_op[FRAC_W-1], "R9", longint'(out_invalid),
                longint'(!in_op[FRAC_W-1]));
        end else if (e == EMAX) begin
            chk(out_result == in_op, "R8", longint'(out_result), longint'(in_op));
            chk(out_inexact == 1'b0, "R8", longint'(out_inexact), 0);
        end else begin
            x  = s ? -mag_of(in_op) : mag_of(in_op);
            fl = x >>> FB;
            ce = fl + ((x - fl * ONE) != 0 ? 1 : 0);
            dl = x - fl * ONE;
            du = ce * ONE - x;
            case (m)
                0: begin
                    if (du < dl)      begin r = ce; tag = "R2"; end
                    else if (du > dl) begin r = fl; tag = "R2"; end
                    else begin r = (ce % 2 == 0) ? ce : fl; tag = "R3"; end
                end
                1:       begin r = (x > 0) ? fl : ce; tag = "R4"; end
                2:       begin r = ce; tag = "R5"; end
                default: begin r = fl; tag = "R6"; end
            endcase
            if (e < BIAS) tag = {tag, "/R11"};
            else if (e >= BIAS + FRAC_W) tag = {tag, "/R8"};
            r = (r < 0) ? -r : r;
            chk(out_result[W-2:FRAC_W] != EXP_W'(EMAX) && mag_of(out_result) == r * ONE,
                tag, mag_of(out_result), r * ONE);
            chk(out_result[W-1] == s, "R10", longint'(out_result[W-1]), longint'(s));
            chk(out_inexact == ((x < 0 ? -x : x) != r * ONE), "R7",
                longint'(out_inexact), longint'((x < 0 ? -x : x) != r * ONE));
            chk(out_invalid == 1'b0, "R9", longint'(out_invalid), 0);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0 && out_result == '0, "R12", longint'(out_result), 0);
        chk(out_inexact == 1'b0 && out_invalid == 1'b0, "R12",
            longint'({out_inexact, out_invalid}), 0);
        rst_n = 1'b1;
        for (int m = 0; m < 4; m++) begin
            for (int k = 0; k < (1 << W); k++) begin
                run_one(k, m);
            end
        end
        // Signaling NaN followed by an idle cycle: flags must drop with valid (R12)
        run_one((EMAX << FRAC_W) | 1, 0);
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", longint'(out_valid), 0);
        chk(out_inexact == 1'b0 && out_invalid == 1'b0, "R12",
            longint'({out_inexact, out_invalid}), 0);
        finish_run();
    end

endmodule